// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block produces the word addresses of a synchronous burst read from a parallel NOR-style memory array. A one-cycle start request loads a first word address, a 3-bit length code, and a control bit that turns wrapping off. After that the block presents one word address per active clock edge, together with a valid strobe. It stops when the burst length is used up, when a continuous burst reaches the top of the burstable space, or when the abort input is raised.

Fixed bursts are 4, 8 or 16 words long. A fixed burst either wraps inside its length-aligned block or counts straight on across the block boundary. A continuous burst always counts linearly and ignores the wrap control. An edge-select input chooses which clock edge drives every register: the rising edge or the falling edge. The array, the data path and the wait-state latency are handled by neighbouring logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_vld` is 0 and `addr_o` is 0.
- R2: `len_code` 3'b001 selects 4 words, 3'b010 selects 8 words and 3'b011 selects 16 words. Every other code, 3'b111 included, selects a continuous burst. A fixed burst presents exactly its length in words, and `addr_vld` falls on the next active edge.
- R3: With `no_wrap` = 1, each word of a fixed burst is the previous word plus one, and it carries across the aligned block boundary. For example, a 4-word burst starting at 3 gives 3,4,5,6.
- R4: With `no_wrap` = 0, only the low log2(length) address bits of a fixed burst increment, and they wrap to zero. The upper bits stay at their start value. For example, a 4-word burst starting at 3 gives 3,0,1,2.
- R5: A continuous burst counts linearly whatever the value of `no_wrap`. It presents END_ADDR once and then drops `addr_vld`.
- R6: With `edge_fall` = 0, every state change occurs on the rising edge of `clk`. With `edge_fall` = 1, every state change occurs on the falling edge. `edge_fall` may change only while `rst_n` is low.
- R7: When the block is idle, a `start` sampled on an active edge makes `addr_vld` high and sets `addr_o` to `start_addr` on that same edge.
- R8: A `start` that arrives while `addr_vld` is high is ignored. The running burst goes on unchanged.
- R9: When `abort` is sampled high while `addr_vld` is high, `addr_vld` falls on that edge. An `abort` sampled while the block is idle has no effect.
- R10: While a burst continues, `addr_o` takes exactly one new value per active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_fall | input | 1 | 0 = rising-edge operation, 1 = falling-edge operation |
| start | input | 1 | Burst request, taken only when idle |
| start_addr | input | AW | First word address |
| len_code | input | 3 | Burst length code |
| no_wrap | input | 1 | 1 = linear fixed bursts, 0 = wrap inside aligned block |
| abort | input | 1 | Ends the running burst |
| addr_o | output | AW | Current word address |
| addr_vld | output | 1 | High while `addr_o` is a burst word |

## Verification
The bound checker tracks each burst's mode from its start request, and it checks the following on every active edge:
- the step from one word to the next, in both wrap and linear mode;
- that the strobe falls after the last fixed word, after the end address, and after an abort;
- that a burst only begins at the requested address.

The edge selection, the exact word lists for each start offset, and the fact that a start during a burst has no effect are shown only by the bench scenarios. The bench compares the full expected sequences and also samples on the inactive clock edge.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
    localparam int LEN_CODE_W = 3;
    localparam int MASK_W     = 4;            // log2 of the longest fixed burst
    localparam int CNT_W      = MASK_W + 1;   // holds a count up to 16
    localparam int WORDS_S    = 4;
    localparam int WORDS_M    = 8;
    localparam int WORDS_L    = 16;

    localparam logic [LEN_CODE_W-1:0] CODE_S = 3'b001;
    localparam logic [LEN_CODE_W-1:0] CODE_M = 3'b010;
    localparam logic [LEN_CODE_W-1:0] CODE_L = 3'b011;

    typedef struct packed {
        logic              fixed;
        logic [MASK_W-1:0] mask;
        logic [CNT_W-1:0]  words;
    } len_info_t;
endpackage

// File: rtl/burst_edge_clk.sv
`timescale 1ns/1ps
module burst_edge_clk (
    input  logic clk,
    input  logic fall_sel,
    output logic clk_act
);
    // An inverted clock makes the falling edge the active one; fall_sel is static
    assign clk_act = clk ^ fall_sel;
endmodule

// File: rtl/burst_len_decode.sv
`timescale 1ns/1ps
module burst_len_decode
    import burst_seq_pkg::*;
(
    input  logic [LEN_CODE_W-1:0] code,
    output len_info_t             info
);
    always_comb begin
        info = '{fixed: 1'b0, mask: '0, words: '0};
        case (code)
            CODE_S: info = '{fixed: 1'b1, mask: MASK_W'(WORDS_S - 1), words: CNT_W'(WORDS_S)};
            CODE_M: info = '{fixed: 1'b1, mask: MASK_W'(WORDS_M - 1), words: CNT_W'(WORDS_M)};
            CODE_L: info = '{fixed: 1'b1, mask: MASK_W'(WORDS_L - 1), words: CNT_W'(WORDS_L)};
            default: info = '{fixed: 1'b0, mask: '0, words: '0};
        endcase
    end
endmodule

// File: rtl/burst_addr_step.sv
`timescale 1ns/1ps
module burst_addr_step #(
    parameter int AW = 25,
    parameter int MW = 4
) (
    input  logic [AW-1:0] cur,
    input  logic [MW-1:0] mask,
    input  logic          wrap_en,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] inc;
    assign inc = cur + AW'(1);

    // Bits outside the wrap window hold their value when wrapping
    for (genvar i = 0; i < AW; i++) begin : g_bit
        if (i < MW) begin : g_low
            assign nxt[i] = (wrap_en && !mask[i]) ? cur[i] : inc[i];
        end else begin : g_high
            assign nxt[i] = wrap_en ? cur[i] : inc[i];
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int            AW       = 25,
    parameter logic [AW-1:0] END_ADDR = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  edge_fall,
    input  logic                  start,
    input  logic [AW-1:0]         start_addr,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  no_wrap,
    input  logic                  abort,
    output logic [AW-1:0]         addr_o,
    output logic                  addr_vld
);
    typedef struct packed {
        logic              vld;
        logic              fixed;
        logic              wrap;
        logic [MASK_W-1:0] mask;
        logic [CNT_W-1:0]  words;
        logic [CNT_W-1:0]  cnt;
        logic [AW-1:0]     addr;
    } seq_st_t;

    seq_st_t   st_d, st_q;
    logic      clk_act;
    len_info_t info;
    logic [AW-1:0] step_nxt;
    logic      at_end;

    burst_edge_clk u_clk (
        .clk      (clk),
        .fall_sel (edge_fall),
        .clk_act  (clk_act)
    );

    burst_len_decode u_dec (
        .code (len_code),
        .info (info)
    );

    burst_addr_step #(.AW(AW), .MW(MASK_W)) u_step (
        .cur     (st_q.addr),
        .mask    (st_q.mask),
        .wrap_en (st_q.wrap),
        .nxt     (step_nxt)
    );

    assign at_end = st_q.fixed ? (st_q.cnt == st_q.words) : (st_q.addr >= END_ADDR);

    always_comb begin
        st_d = st_q;
        if (!st_q.vld) begin
            if (start) begin
                st_d.vld   = 1'b1;
                st_d.addr  = start_addr;
                st_d.fixed = info.fixed;
                st_d.wrap  = info.fixed & ~no_wrap;
                st_d.mask  = info.mask;
                st_d.words = info.words;
                st_d.cnt   = CNT_W'(1);
            end
        end else if (abort || at_end) begin
            st_d.vld = 1'b0;
        end else begin
            st_d.addr = step_nxt;
            if (st_q.fixed) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_act or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign addr_vld = st_q.vld;
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk #(
    parameter int            AW       = 25,
    parameter logic [AW-1:0] END_ADDR = '1
) (
    input logic          clk_act,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic [2:0]    len_code,
    input logic          no_wrap,
    input logic          abort,
    input logic [AW-1:0] addr_o,
    input logic          addr_vld
);
    logic          c_fixed, c_wrap;
    logic [AW-1:0] c_mask;
    logic [5:0]    c_len, c_cnt;

    always_ff @(posedge clk_act or negedge rst_n) begin
        if (!rst_n) begin
            c_fixed <= 1'b0;
            c_wrap  <= 1'b0;
            c_mask  <= '0;
            c_len   <= '0;
            c_cnt   <= '0;
        end else if (!addr_vld && start) begin
            c_cnt <= 6'd1;
            case (len_code)
                3'b001:  begin c_fixed <= 1'b1; c_len <= 6'd4;  c_mask <= AW'(3);  end
                3'b010:  begin c_fixed <= 1'b1; c_len <= 6'd8;  c_mask <= AW'(7);  end
                3'b011:  begin c_fixed <= 1'b1; c_len <= 6'd16; c_mask <= AW'(15); end
                default: begin c_fixed <= 1'b0; c_len <= 6'd0;  c_mask <= '0;      end
            endcase
            c_wrap <= !no_wrap && (len_code == 3'b001 || len_code == 3'b010 || len_code == 3'b011);
        end else if (addr_vld) begin
            c_cnt <= c_cnt + 6'd1;
        end
    end

    // R2
    fixed_len_bound_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (addr_vld && c_fixed) |-> (c_cnt <= c_len));

    // R2
    fixed_len_end_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (addr_vld && c_fixed && c_cnt == c_len) |=> !addr_vld);

    // R3
    linear_step_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (addr_vld && $past(addr_vld) && !c_wrap) |-> (addr_o == $past(addr_o) + AW'(1)));

    // R4
    wrap_step_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (addr_vld && $past(addr_vld) && c_wrap) |->
        (addr_o == (($past(addr_o) & ~c_mask) | (($past(addr_o) + AW'(1)) & c_mask))));

    // R5
    cont_end_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (addr_vld && !c_fixed && addr_o >= END_ADDR) |=> !addr_vld);

    // R7
    start_load_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        $rose(addr_vld) |-> ($past(start) && addr_o == $past(start_addr)));

    // R9
    abort_stop_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (addr_vld && abort) |=> !addr_vld);

    // R9
    idle_hold_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
        (!addr_vld && !start) |=> !addr_vld);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .END_ADDR(END_ADDR)) u_chk (
    .clk_act    (clk_act),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .len_code   (len_code),
    .no_wrap    (no_wrap),
    .abort      (abort),
    .addr_o     (addr_o),
    .addr_vld   (addr_vld)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
    localparam int            AW    = 25;
    localparam logic [AW-1:0] END_A = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          edge_fall = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [2:0]    len_code = 3'b001;
    logic          no_wrap = 1'b1;
    logic          abort = 1'b0;
    logic [AW-1:0] addr_o;
    logic          addr_vld;

    int total = 0;
    int bad = 0;
    logic fall_mode = 1'b0;
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    burst_addr_seq #(.AW(AW), .END_ADDR(END_A)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_fall  (edge_fall),
        .start      (start),
        .start_addr (start_addr),
        .len_code   (len_code),
        .no_wrap    (no_wrap),
        .abort      (abort),
        .addr_o     (addr_o),
        .addr_vld   (addr_vld)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_act();
        if (fall_mode) @(negedge clk);
        else @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: one pop per active edge while the strobe is high (R10)
    initial begin
        forever begin
            wait_act();
            if (rst_n && addr_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 extra word", addr_o, '0);
                end else begin
                    automatic logic [AW-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(addr_o == e, t, addr_o, e);
                end
            end
        end
    end

    task automatic push_seq(input logic [AW-1:0] a, input logic [2:0] code, input logic nw, input string req);
        int n;
        logic [AW-1:0] m;
        bit wr;
        case (code)
            3'b001:  begin n = 4;  m = AW'(3);  end
            3'b010:  begin n = 8;  m = AW'(7);  end
            3'b011:  begin n = 16; m = AW'(15); end
            default: begin n = int'(END_A - a) + 1; m = '0; end
        endcase
        wr = (m != '0) && !nw;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(wr ? ((a & ~m) | ((a + AW'(i)) & m)) : a + AW'(i));
            tag_q.push_back(req);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [2:0] code, input logic nw);
        start_addr = a;
        len_code   = code;
        no_wrap    = nw;
        start      = 1'b1;
        wait_act();
        start      = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 64 && addr_vld; k++) wait_act();
        check(exp_q.size() == 0 && !addr_vld, req, AW'(exp_q.size()), '0);
        exp_q.delete();
        tag_q.delete();
        wait_act();
    endtask

    task automatic run_burst(input logic [AW-1:0] a, input logic [2:0] code, input logic nw, input string req);
        push_seq(a, code, nw, req);
        issue(a, code, nw);
        drain(req);
    endtask

    task automatic do_reset(input logic fall);
        wait_act();
        rst_n     = 1'b0;
        edge_fall = fall;
        fall_mode = fall;
        #3;
        check(!addr_vld, "R1 vld", AW'(addr_vld), '0);
        check(addr_o == '0, "R1 addr", addr_o, '0);
        wait_act();
        wait_act();
        rst_n = 1'b1;
        wait_act();
    endtask

    initial begin
        #1_000_000;
        check(1'b0, "watchdog", '0, '0);
        summary();
        $finish;
    end

    initial begin
        do_reset(1'b0);

        run_burst(AW'('h0AB3), 3'b001, 1'b1, "R3 len4 linear");
        run_burst(AW'('h1207), 3'b010, 1'b1, "R3 len8 linear");
        run_burst(AW'('h0AB3), 3'b001, 1'b0, "R4 len4 wrap");
        run_burst(AW'('h155D), 3'b011, 1'b0, "R4 len16 wrap");
        run_burst(AW'('h300E), 3'b010, 1'b0, "R4 len8 wrap");
        run_burst(AW'('h4000), 3'b011, 1'b1, "R2 len16 linear");
        run_burst(END_A - AW'(5), 3'b111, 1'b0, "R5 continuous end");
        run_burst(END_A - AW'(2), 3'b100, 1'b1, "R2 other code continuous");

        // R9: abort during a continuous burst after five words
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(AW'('h100) + AW'(i));
            tag_q.push_back("R9 abort");
        end
        issue(AW'('h100), 3'b111, 1'b1);
        for (int i = 0; i < 4; i++) wait_act();
        abort = 1'b1;
        wait_act();
        abort = 1'b0;
        drain("R9 abort stop");

        // R9: abort while idle has no effect
        abort = 1'b1;
        wait_act();
        wait_act();
        check(!addr_vld, "R9 idle abort", AW'(addr_vld), '0);
        abort = 1'b0;
        wait_act();

        // R8: start during a burst is ignored
        push_seq(AW'('h200), 3'b010, 1'b1, "R8 restart ignored");
        issue(AW'('h200), 3'b010, 1'b1);
        wait_act();
        wait_act();
        start_addr = AW'('h900);
        len_code   = 3'b001;
        no_wrap    = 1'b0;
        start      = 1'b1;
        wait_act();
        start      = 1'b0;
        drain("R8 restart ignored");

        // R7: back-to-back start after idle
        run_burst(AW'('h0), 3'b001, 1'b1, "R7 start load");

        // R6: falling-edge operation
        do_reset(1'b1);
        push_seq(AW'('h7), 3'b001, 1'b0, "R6 fall wrap");
        start_addr = AW'('h7);
        len_code   = 3'b001;
        no_wrap    = 1'b0;
        start      = 1'b1;
        @(posedge clk);
        #2;
        check(!addr_vld, "R6 no rise-edge start", AW'(addr_vld), '0);
        @(negedge clk);
        #2;
        start = 1'b0;
        @(posedge clk);
        #2;
        check(addr_vld && addr_o == AW'('h7), "R6 stable on rise edge", addr_o, AW'('h7));
        @(negedge clk);
        #2;
        drain("R6 fall wrap");
        run_burst(END_A - AW'(3), 3'b111, 1'b1, "R6 fall continuous");

        summary();
        $finish;
    end
endmodule